// File: doc/BRIEF.md
# Two-Edge Input Debounce Filter

This block cleans up a vector of asynchronous interrupt request lines before they reach interrupt detection logic. It runs on a dedicated, slow debounce clock. A request level is accepted only after that clock has sampled the same level on two consecutive rising edges. A short glitch that is seen by only one sampling edge, or by none, is discarded.

Each line has its own enable, which software normally holds in a configuration register. When a line's enable is set, the filtered level is presented. When it is clear, the raw line is passed combinationally to the output, with no added latency. Crossing the output into the bus clock domain and detecting interrupts are left to the logic that follows.

The block has its own active-low reset. The reset takes effect asynchronously, and a small synchronizer built from asynchronously reset flip-flops releases it on a debounce clock edge. Every storage element in the block uses an asynchronous reset.

Top module: `dbf_input_filter`

## Requirements
- R1: With a bit's enable at 1, when its raw input is sampled 1 on two consecutive rising debounce-clock edges k and k+1, that bit of `filt_out` is 1 after edge k+2. This adds two debounce cycles of latency, and a level held for three periods always propagates.
- R2: With a bit's enable at 1, when its raw input is sampled 0 on two consecutive rising edges k and k+1, that bit of `filt_out` is 0 after edge k+2.
- R3: A pulse between one and two periods long that covers only one rising edge leaves the enabled output unchanged. A pulse that covers two rising edges propagates.
- R4: A pulse shorter than one debounce period never changes the enabled output.
- R5: With a bit's enable at 0, that bit of `filt_out` equals the raw input at all times, with no clock edge needed.
- R6: Enables act per bit. An enabled bit and a disabled bit follow their own rules under the same stimulus.
- R7: While `dbc_arst_n` is 0, every enabled output bit is 0 immediately, without a clock edge, and all filter stages are cleared.
- R8: When `dbc_arst_n` rises before edge j, the internal reset is released at edge j+1. With the raw input held at 1, an enabled output is 0 after edge j+3 and 1 after edge j+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dbc_clk | input | 1 | Debounce sampling clock |
| dbc_arst_n | input | 1 | Active-low reset, asynchronous assertion |
| raw_in | input | WIDTH | Raw asynchronous request lines |
| filt_en | input | WIDTH | Per-bit filter enable (1 = filtered, 0 = pass-through) |
| filt_out | output | WIDTH | Filtered or passed-through request lines |

## Verification
The hardest case to produce is a pulse whose outcome depends on where it falls relative to the sampling edges. A pulse of one and a half periods must be accepted at some phases and rejected at others. The bench launches pulses of one half, one and a half, and three periods from several sub-cycle offsets after a clock edge. For each pulse it computes how many rising edges the pulse covers and from that whether the output must ever rise. The reset release is tested with the input already high, so that the exact edge at which filtering restarts shows up in the output.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

   // Next filtered level from a window of samples and the held level.
   function automatic logic dbf_next_level(input logic all_one,
                                           input logic all_zero,
                                           input logic held);
      logic nxt;
      if (all_one)       nxt = 1'b1;
      else if (all_zero) nxt = 1'b0;
      else               nxt = held;
      return nxt;
   endfunction

endpackage

// File: rtl/dbf_rst_sync.sv
module dbf_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dbf_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_out = chain[STAGES-1];

   // R7: a low external reset forces the internal reset low.
   p_reset_hold_r7: assert property (@(posedge clk)
      !arst_n |-> !rst_n_out);

   // R8: the release is only seen after the external reset was already high.
   p_release_sync_r8: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n_out) |-> $past(arst_n));

endmodule

// File: rtl/dbf_bit.sv
module dbf_bit
   import dbf_pkg::*;
#(
   parameter int SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic en,
   output logic y
);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("dbf_bit: SAMPLES must be at least 2");
   end

   logic [SAMPLES-1:0] stg;
   logic               held;
   logic               all_one;
   logic               all_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[SAMPLES-2:0], raw};
   end

   assign all_one  = &stg;
   assign all_zero = ~|stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b0;
      else        held <= dbf_next_level(all_one, all_zero, held);
   end

   assign y = en ? held : raw;

   // R1: a full window of ones gives a high level on the next edge.
   p_rise_after_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      all_one |=> held);

   // R2: a full window of zeros gives a low level on the next edge.
   p_fall_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      all_zero |=> !held);

   // R3: a mixed window never moves the held level.
   p_mixed_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_one && !all_zero) |=> $stable(held));

   // R7: during reset the held level is clear.
   p_clear_in_reset_r7: assert property (@(posedge clk)
      !rst_n |-> !held);

endmodule

// File: rtl/dbf_input_filter.sv
module dbf_input_filter #(
   parameter int WIDTH      = 8,
   parameter int SAMPLES    = 2,
   parameter int RST_STAGES = 2
) (
   input  logic             dbc_clk,
   input  logic             dbc_arst_n,
   input  logic [WIDTH-1:0] raw_in,
   input  logic [WIDTH-1:0] filt_en,
   output logic [WIDTH-1:0] filt_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dbf_input_filter: WIDTH must be at least 1");
   end

   logic rst_int_n;
   logic rst_gate_n;

   dbf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk       (dbc_clk),
      .arst_n    (dbc_arst_n),
      .rst_n_out (rst_int_n)
   );

   // Assertion stays asynchronous; release follows the synchronizer.
   assign rst_gate_n = rst_int_n & dbc_arst_n;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      dbf_bit #(.SAMPLES(SAMPLES)) u_bit (
         .clk   (dbc_clk),
         .rst_n (rst_gate_n),
         .raw   (raw_in[i]),
         .en    (filt_en[i]),
         .y     (filt_out[i])
      );
   end

endmodule

// File: tb/sim_dbf_input_filter.sv
`timescale 1ns/1ps
module sim_dbf_input_filter;

   localparam int W = 4;
   localparam int P = 20;

   logic         clk = 1'b0;
   logic         arst_n = 1'b0;
   logic [W-1:0] raw = '0;
   logic [W-1:0] en = '1;
   logic [W-1:0] out;

   int checks = 0;
   int errors = 0;
   bit track = 0;
   bit seen = 0;

   always #(P/2) clk = ~clk;

   dbf_input_filter #(.WIDTH(W), .SAMPLES(2), .RST_STAGES(2)) u0 (
      .dbc_clk    (clk),
      .dbc_arst_n (arst_n),
      .raw_in     (raw),
      .filt_en    (en),
      .filt_out   (out)
   );

   always @(negedge clk) if (track && out[1]) seen = 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(200000 * P);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int w_tab[3];
      int p_tab[5];
      w_tab = '{10, 30, 60};
      p_tab = '{1, 3, 7, 12, 17};

      // R7: reset state without any clock dependence
      #3;
      chk(out == 4'b0000, "R7 reset state", int'(out), 0);

      // R8: release with raw held high on bit 0
      raw[0] = 1'b1;
      repeat (3) @(posedge clk);
      #5 arst_n = 1'b1;            // edge j is 15 ns later
      #(15 + 3*P + 10);            // between j+3 and j+4
      chk(out[0] == 1'b0, "R8 low after j+3", int'(out[0]), 0);
      #P;
      chk(out[0] == 1'b1, "R8 high after j+4", int'(out[0]), 1);

      // R2: fall latency
      @(posedge clk); #5 raw[0] = 1'b0;
      #(2*P + 5);
      chk(out[0] == 1'b1, "R2 held before k+2", int'(out[0]), 1);
      #P;
      chk(out[0] == 1'b0, "R2 low after k+2", int'(out[0]), 0);

      // R1: rise latency
      @(posedge clk); #5 raw[0] = 1'b1;
      #(2*P + 5);
      chk(out[0] == 1'b0, "R1 low before k+2", int'(out[0]), 0);
      #P;
      chk(out[0] == 1'b1, "R1 high after k+2", int'(out[0]), 1);

      // R5: pass-through without clock edges
      en[2] = 1'b0;
      @(posedge clk); #3 raw[2] = 1'b1; #1;
      chk(out[2] == 1'b1, "R5 pass high", int'(out[2]), 1);
      #2 raw[2] = 1'b0; #1;
      chk(out[2] == 1'b0, "R5 pass low", int'(out[2]), 0);

      // R6: same short pulse on enabled bit 3 and disabled bit 2
      @(posedge clk); #4 raw[3:2] = 2'b11; #2;
      chk(out[2] == 1'b1, "R6 disabled bit follows", int'(out[2]), 1);
      chk(out[3] == 1'b0, "R6 enabled bit filtered", int'(out[3]), 0);
      #3 raw[3:2] = 2'b00;
      repeat (4) @(posedge clk); #5;
      chk(out[3] == 1'b0, "R6 enabled bit stays low", int'(out[3]), 0);

      // Phase and width sweep on bit 1
      for (int wi = 0; wi < 3; wi++) begin
         for (int pi = 0; pi < 5; pi++) begin
            int w;
            int ph;
            int edges;
            bit exp;
            w = w_tab[wi];
            ph = p_tab[pi];
            edges = (ph + w) / P;
            exp = (edges >= 2);
            seen = 0;
            track = 1;
            @(posedge clk); #(ph) raw[1] = 1'b1;
            #(w) raw[1] = 1'b0;
            repeat (6) @(posedge clk);
            #5;
            track = 0;
            if (w < P)
               chk(seen == 1'b0, "R4 sub-period glitch", int'(seen), 0);
            else if (w > 2*P)
               chk(seen == 1'b1, "R1 three-period pulse", int'(seen), 1);
            else
               chk(seen == exp, "R3 edge-count decides", int'(seen), int'(exp));
            chk(out[1] == 1'b0, "R2 returns low", int'(out[1]), 0);
         end
      end

      // R7: asynchronous clear mid-cycle while bit 0 is high
      chk(out[0] == 1'b1, "R7 precondition high", int'(out[0]), 1);
      raw[2] = 1'b1;
      @(posedge clk); #4 arst_n = 1'b0; #1;
      chk(out[0] == 1'b0, "R7 async clear", int'(out[0]), 0);
      chk(out[2] == 1'b1, "R7 disabled bit passes", int'(out[2]), 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule